// File: doc/BRIEF.md
# 10-bit ECC Value Byte Packer

This block converts eight 10-bit error-correction code values to and from the ten-byte image kept in a flash page's spare area. In the pack direction it takes four 32-bit words on a single start strobe. Each word carries two values, one in its low half and one in its high half. The block then streams out ten bytes over a valid/ready handshake, one byte for each accepted cycle.

In the unpack direction it accepts ten bytes over a valid/ready handshake. It splits them back into eight values and presents those values on a load port, one per cycle, starting with the highest index. The load port feeds the correction engine's code-load input.

The packing is one continuous little-endian bit stream. Value i occupies stream bits [10i+9:10i], and byte k is stream bits [8k+7:8k], so fields straddle byte boundaries. One control state machine serves both directions. Its states are IDLE, EMIT, COLLECT and LOAD. The transitions are:
- IDLE to EMIT, on a start strobe.
- IDLE to COLLECT, when a first input byte is accepted.
- EMIT to IDLE, after the tenth byte is accepted.
- COLLECT to LOAD, after the tenth byte is taken.
- LOAD to IDLE, after index 0 has been presented.

Top module: `ecc10_byte_packer`

## Requirements
- R1: Only bits [9:0] and [25:16] of each input word affect the packed bytes; all other word bits are ignored.
- R2: Value 2j is bits [9:0] of word j (word j is pack_words[32j+31:32j]) and value 2j+1 is bits [25:16] of word j; the emitted bytes 0..9, in that order, are the 80-bit stream whose bits [10i+9:10i] hold value i, byte k taking stream bits [8k+7:8k].
- R3: out_valid rises the cycle after an accepted start; one byte advances per cycle with out_valid and out_ready both high, and out_data stays stable while out_ready is low.
- R4: The ten accepted input bytes, first byte lowest, form an 80-bit stream; value i is stream bits [10i+9:10i].
- R5: After the tenth input byte, load_valid is high for eight consecutive cycles, with load_index 7, 6, ... 0 and load_value equal to the value of that index.
- R6: done is a one-cycle pulse in the cycle after the tenth output byte is accepted or after load index 0 is presented, and at no other time.
- R7: In IDLE a start strobe wins over a waiting input byte (in_ready is low in that cycle). in_ready stays low while bytes are emitted, and a start strobe during a transfer is ignored.
- R8: During and after reset the block is in IDLE: out_valid, load_valid and done are low and in_ready is high.
- R9: Unpacking the ten bytes produced by a pack reproduces all eight original values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pack_start | input | 1 | Start a pack; taken in IDLE only |
| pack_words | input | 128 | Four source words, word j at bits [32j+31:32j] |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Consumer accepts the packed byte |
| out_data | output | 8 | Packed byte |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte of the stored image |
| load_valid | output | 1 | Load port strobe |
| load_index | output | 3 | Index of the value being loaded |
| load_value | output | 10 | Unpacked value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs values whose low bits fall in bytes other than their high bits, such as a value of 0x03F at index 1. A design that misplaced a straddling field would put 0xFC somewhere other than byte 1, or would return a truncated value on unpack. Pack stimulus carries junk in the unused word bits, so a design that failed to mask would produce corrupted bytes. Random output stalls check that a design cannot drop or repeat a byte, or change it while held. Colliding start and input strobes, and a start pulsed mid-stream, show whether a design would accept a stray byte or restart its stream. The load sequence is compared index by index, so ascending or off-by-one ordering is reported.

// File: rtl/ecc10_byte_packer_pkg.sv
package ecc10_byte_packer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_EMIT    = 2'd1,
        ST_COLLECT = 2'd2,
        ST_LOAD    = 2'd3
    } pk_state_e;
endpackage

// File: rtl/ecc10_ctrl.sv
module ecc10_ctrl
    import ecc10_byte_packer_pkg::*;
#(
    parameter int N_BYTE = 10,
    parameter int N_VAL  = 8,
    localparam int CNT_W = $clog2(N_BYTE),
    localparam int IDX_W = $clog2(N_VAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pack_start,
    input  logic             out_ready,
    input  logic             in_valid,
    output logic             out_valid,
    output logic             in_ready,
    output logic             load_valid,
    output logic [IDX_W-1:0] load_index,
    output logic             done,
    output logic             cap_en,
    output logic             shift_out,
    output logic             shift_in
);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(N_BYTE - 1);
    localparam logic [CNT_W-1:0] TOP_IDX   = CNT_W'(N_VAL - 1);

    pk_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pack_start) begin
                    state_d = ST_EMIT;
                    cnt_d   = '0;
                end else if (in_valid) begin
                    state_d = ST_COLLECT;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (cnt_q == LAST_BYTE) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_COLLECT: begin
                if (in_valid) begin
                    if (cnt_q == LAST_BYTE) begin
                        state_d = ST_LOAD;
                        cnt_d   = TOP_IDX;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done    <= done_d;
        end
    end

    // outputs
    always_comb begin
        out_valid  = 1'b0;
        in_ready   = 1'b0;
        load_valid = 1'b0;
        cap_en     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = !pack_start;
                cap_en   = pack_start;
            end
            ST_EMIT:    out_valid  = 1'b1;
            ST_COLLECT: in_ready   = 1'b1;
            ST_LOAD:    load_valid = 1'b1;
            default: ;
        endcase
        load_index = cnt_q[IDX_W-1:0];
        shift_out  = out_valid && out_ready;
        shift_in   = in_valid && in_ready;
    end
endmodule

// File: rtl/ecc10_pack.sv
module ecc10_pack #(
    parameter int N_VAL  = 8,
    parameter int VAL_W  = 10,
    parameter int SLOT_W = 16,
    parameter int WORD_W = 32,
    localparam int IMG_W = N_VAL * VAL_W,
    localparam int WDS_W = (N_VAL / 2) * WORD_W
) (
    input  logic [WDS_W-1:0] words,
    output logic [IMG_W-1:0] img
);
    for (genvar i = 0; i < N_VAL; i++) begin : g_val
        assign img[i*VAL_W +: VAL_W] = words[(i/2)*WORD_W + (i%2)*SLOT_W +: VAL_W];
    end

    logic unused_bits;
    assign unused_bits = ^words;
endmodule

// File: rtl/ecc10_unpack.sv
module ecc10_unpack #(
    parameter int N_VAL  = 8,
    parameter int VAL_W  = 10,
    localparam int IMG_W = N_VAL * VAL_W,
    localparam int IDX_W = $clog2(N_VAL)
) (
    input  logic [IMG_W-1:0] img,
    input  logic [IDX_W-1:0] idx,
    output logic [VAL_W-1:0] value
);
    logic [VAL_W-1:0] vals [N_VAL];

    for (genvar i = 0; i < N_VAL; i++) begin : g_val
        assign vals[i] = img[i*VAL_W +: VAL_W];
    end

    assign value = vals[idx];
endmodule

// File: rtl/ecc10_byte_packer.sv
module ecc10_byte_packer #(
    parameter int N_VAL  = 8,
    parameter int VAL_W  = 10,
    parameter int BYTE_W = 8,
    parameter int SLOT_W = 16,
    parameter int WORD_W = 32,
    localparam int IMG_W  = N_VAL * VAL_W,
    localparam int N_BYTE = IMG_W / BYTE_W,
    localparam int WDS_W  = (N_VAL / 2) * WORD_W,
    localparam int IDX_W  = $clog2(N_VAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_start,
    input  logic [WDS_W-1:0]  pack_words,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              load_valid,
    output logic [IDX_W-1:0]  load_index,
    output logic [VAL_W-1:0]  load_value,
    output logic              done
);
    logic             cap_en, shift_out, shift_in;
    logic [IMG_W-1:0] packed_img;
    logic [IMG_W-1:0] img_q;

    ecc10_ctrl #(.N_BYTE(N_BYTE), .N_VAL(N_VAL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pack_start (pack_start),
        .out_ready  (out_ready),
        .in_valid   (in_valid),
        .out_valid  (out_valid),
        .in_ready   (in_ready),
        .load_valid (load_valid),
        .load_index (load_index),
        .done       (done),
        .cap_en     (cap_en),
        .shift_out  (shift_out),
        .shift_in   (shift_in)
    );

    ecc10_pack #(.N_VAL(N_VAL), .VAL_W(VAL_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_pack (
        .words (pack_words),
        .img   (packed_img)
    );

    // shared byte image: loaded whole, drained low-first, filled from the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (cap_en) begin
            img_q <= packed_img;
        end else if (shift_out) begin
            img_q <= img_q >> BYTE_W;
        end else if (shift_in) begin
            img_q <= {in_data, img_q[IMG_W-1:BYTE_W]};
        end
    end

    assign out_data = img_q[BYTE_W-1:0];

    ecc10_unpack #(.N_VAL(N_VAL), .VAL_W(VAL_W)) u_unpack (
        .img   (img_q),
        .idx   (load_index),
        .value (load_value)
    );
endmodule

// File: rtl/ecc10_byte_packer_chk.sv
module ecc10_byte_packer_chk #(
    parameter int N_VAL  = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(N_VAL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              in_ready,
    input logic              load_valid,
    input logic [IDX_W-1:0]  load_index,
    input logic              done
);
    p_dir_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!in_ready && !load_valid));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_first_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_valid) |-> (load_index == IDX_W'(N_VAL - 1)));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_index != '0) |=>
            (load_valid && load_index == IDX_W'($past(load_index) - 1'b1)));

    p_done_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) || $past(load_valid && load_index == '0)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_reset_r8: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && !load_valid && !done && in_ready));
endmodule

bind ecc10_byte_packer ecc10_byte_packer_chk #(.N_VAL(N_VAL), .BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .in_ready   (in_ready),
    .load_valid (load_valid),
    .load_index (load_index),
    .done       (done)
);

// File: tb/sim_ecc10_byte_packer.sv
module sim_ecc10_byte_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pack_start = 1'b0;
    logic [127:0] pack_words = '0;
    logic         out_valid, in_ready, load_valid, done;
    logic         out_ready = 1'b1;
    logic [7:0]   out_data;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic [2:0]   load_index;
    logic [9:0]   load_value;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  byte_q [$];
    logic [12:0] ld_q [$];
    logic [7:0]  cap_q [$];

    bit stall_en = 1'b0;
    int tick = 0;

    always #4 clk = ~clk;

    ecc10_byte_packer u0 (
        .clk(clk), .rst_n(rst_n), .pack_start(pack_start), .pack_words(pack_words),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .load_valid(load_valid), .load_index(load_index), .load_value(load_value),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // consumer stall pattern
    always begin
        @(posedge clk);
        #1;
        tick++;
        out_ready = stall_en ? ((tick % 3) != 2) : 1'b1;
    end

    // monitor / scoreboard
    bit         exp_done = 1'b0;
    bit         hold_pend = 1'b0;
    logic [7:0] hold_data;
    int         pk_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit nd;
            nd = 1'b0;
            check(done == exp_done, "R6 done", done, exp_done);
            if (hold_pend) begin
                check(out_valid && out_data == hold_data, "R3 hold", out_data, hold_data);
            end
            hold_pend = out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid && out_ready) begin
                if (byte_q.size() == 0) begin
                    check(1'b0, "R7 unexpected byte", out_data, 0);
                end else begin
                    logic [7:0] e;
                    e = byte_q.pop_front();
                    check(out_data == e, "R2 byte", out_data, e);
                end
                cap_q.push_back(out_data);
                pk_cnt++;
                if (pk_cnt == 10) begin
                    nd = 1'b1;
                    pk_cnt = 0;
                end
            end
            if (load_valid) begin
                if (ld_q.size() == 0) begin
                    check(1'b0, "R5 unexpected load", load_index, 0);
                end else begin
                    logic [12:0] e;
                    e = ld_q.pop_front();
                    check(load_index == e[12:10], "R5 index", load_index, e[12:10]);
                    check(load_value == e[9:0], "R4 value", load_value, e[9:0]);
                end
                if (load_index == 3'd0) nd = 1'b1;
            end
            exp_done = nd;
        end
    end

    function automatic logic [79:0] words_to_img(input logic [127:0] w);
        logic [79:0] img;
        for (int j = 0; j < 4; j++) begin
            img[20*j +: 10]      = w[32*j +: 10];
            img[20*j + 10 +: 10] = w[32*j + 16 +: 10];
        end
        return img;
    endfunction

    task automatic do_pack(input logic [127:0] w);
        logic [79:0] img;
        img = words_to_img(w);
        for (int k = 0; k < 10; k++) byte_q.push_back(img[8*k +: 8]);
        pack_words = w;
        pack_start = 1'b1;
        @(posedge clk);
        #1;
        pack_start = 1'b0;
    endtask

    task automatic push_ld_img(input logic [79:0] img);
        for (int i = 7; i >= 0; i--) ld_q.push_back({3'(i), img[10*i +: 10]});
    endtask

    task automatic send_bytes(input logic [79:0] img, input int gap);
        for (int k = 0; k < 10; k++) begin
            in_valid = 1'b1;
            in_data  = img[8*k +: 8];
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic wait_idle();
        while (byte_q.size() != 0 || ld_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [127:0] w;
        logic [79:0]  img;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !load_valid && !done && in_ready, "R8 reset",
              {out_valid, load_valid, done, in_ready}, 4'b0001);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2 straddling field: value 1 = 0x03F lands as 0xFC in byte 1
        cap_q.delete();
        do_pack(128'h0000_0000_0000_0000_0000_0000_003F_0000);
        wait_idle();
        check(cap_q[1] == 8'hFC, "R2 straddle byte1", cap_q[1], 8'hFC);
        check(cap_q[0] == 8'h00 && cap_q[2] == 8'h00, "R2 neighbours", {cap_q[0], cap_q[2]}, 0);

        // R1 junk in unused bits, R3 with stalls
        stall_en = 1'b1;
        do_pack(128'hFC00_FFFF_A5C3_5A3C_FFFF_FC00_1234_5678);
        wait_idle();
        do_pack(128'h0000_03FF_03FF_0000_03FF_03FF_0000_0000);
        wait_idle();
        stall_en = 1'b0;

        // R4/R5: unpack directed image and patterned image, with gaps
        img = '0;
        img[15:8] = 8'hFC;
        push_ld_img(img);
        send_bytes(img, 0);
        wait_idle();
        img = 80'h9A_5C_13_E7_00_FF_81_42_3D_C6;
        push_ld_img(img);
        send_bytes(img, 2);
        wait_idle();

        // R7: start wins over waiting byte; start mid-stream ignored
        w = 128'h0155_02AA_0123_0321_01FE_0001_0200_03FF;
        img = words_to_img(w);
        for (int k = 0; k < 10; k++) byte_q.push_back(img[8*k +: 8]);
        stall_en = 1'b1;
        pack_words = w;
        pack_start = 1'b1;
        in_valid = 1'b1;
        in_data = 8'hA5;
        @(negedge clk);
        check(in_ready == 1'b0, "R7 start priority", in_ready, 0);
        @(posedge clk);
        #1;
        pack_start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R7 in_ready low while emitting", in_ready, 0);
            @(posedge clk);
            #1;
            if (c == 1) begin
                pack_words = ~w;
                pack_start = 1'b1;
            end else begin
                pack_start = 1'b0;
            end
        end
        in_valid = 1'b0;
        pack_start = 1'b0;
        wait_idle();
        stall_en = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R7 no restart", {out_valid, in_ready}, 2'b01);
        @(posedge clk);
        #1;

        // R9 round trip for several word sets
        for (int t = 0; t < 4; t++) begin
            logic [79:0] orig;
            case (t)
                0: w = 128'h03FF_0000_0000_03FF_0155_02AA_02AA_0155;
                1: w = 128'h0001_0002_0004_0008_0010_0020_0040_0080;
                2: w = 128'h0315_0263_01C7_038E_00F0_030F_0199_0266;
                default: w = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
            endcase
            cap_q.delete();
            stall_en = (t % 2) == 1;
            do_pack(w);
            wait_idle();
            stall_en = 1'b0;
            check(cap_q.size() == 10, "R9 byte count", cap_q.size(), 10);
            img = '0;
            for (int k = 0; k < 10; k++) img[8*k +: 8] = cap_q[k];
            orig = words_to_img(w);
            // expected values come from the original words, not the bytes
            push_ld_img(orig);
            send_bytes(img, t % 2);
            wait_idle();
        end

        finish_run();
    end
endmodule